// File: doc/BRIEF.md
# Punctuation-Driven Sliding Window Aggregator

This unit is one slot of a bank of sliding-window evaluators that work on a stream of tuples arriving in any order. Each tuple carries a timestamp and a value. The unit holds the half-open timestamp interval of the window it currently owns. A tuple whose timestamp falls inside that interval is folded into running COUNT, SUM, MIN and MAX results. Tuples outside the interval are dropped. Nothing is buffered or sorted.

A punctuation beat marks a window as finished. It is a beat with the punctuation flag set, and its timestamp promises that no earlier data will follow. The unit then raises a close strobe in that same cycle and shows its final results together with the end of the finished window. On the next clock edge it jumps its interval forward by `NUM_INST × SLIDE_LEN` so that the slot takes over a later window of the bank. It also clears its aggregates on that edge.

Accept and close are decided combinationally from the current beat. A tuple is therefore fully absorbed in one cycle. An internal state machine has two states, `WS_EMPTY` and `WS_OPEN`. It records whether the current window has absorbed any tuple. The transitions are:
- `WS_EMPTY` to `WS_OPEN` when a tuple is accepted.
- `WS_OPEN` to `WS_EMPTY` when the window closes.
- `WS_EMPTY` stays `WS_EMPTY` when an empty window closes.
- `WS_OPEN` stays `WS_OPEN` when further tuples are accepted.

Top module: `wagg_unit`

## Requirements
- R1: After reset the window begin is `START_TS + (INST_IDX−1)×SLIDE_LEN` and the window end (`win_end_ts`) is begin + `RANGE_LEN`. In the reset state `res_count`=0, `res_sum`=0, `res_min`=0xFFFFFFFF and `res_max`=0.
- R2: A beat with `in_punct`=1 and `in_ts` ≥ window end drives `win_close`=1 in that same cycle. From the next cycle on, begin and end are both larger by `NUM_INST×SLIDE_LEN`.
- R3: A beat with `in_punct`=1 and `in_ts` < window end gives `win_close`=0 and leaves the bounds and the aggregates unchanged.
- R4: A beat with `in_valid`=1, `in_punct`=0 and begin ≤ `in_ts` < end is accepted. From the next cycle `res_count` is larger by one, `res_sum` has `in_val` added, `res_min`=min(old, `in_val`) and `res_max`=max(old, `in_val`).
- R5: A beat with `in_ts` < begin or `in_ts` ≥ end, or with `in_valid`=0, leaves all aggregate outputs unchanged.
- R6: When `in_valid` and `in_punct` are both 1, the beat is treated only as a punctuation. It is never accepted as a tuple.
- R7: `win_close` is 0 in every cycle where `in_punct` is 0.
- R8: In the close cycle, the result outputs and `win_end_ts` still show the finished window's values. In the following cycle the aggregates show the reset values of R1.
- R9: The results do not depend on the arrival order of the tuples inside the window.
- R10: SUM is 32-bit unsigned and wraps modulo 2^32.
- R11: While the state is `WS_EMPTY`, the aggregates hold their reset values. A close of an empty window still advances the bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat carries a data tuple |
| in_punct | input | 1 | Beat is a punctuation |
| in_ts | input | 32 | Windowing timestamp of the beat |
| in_val | input | 32 | Value field aggregated by the unit |
| win_close | output | 1 | Current window finishes in this cycle |
| win_end_ts | output | 32 | Exclusive end timestamp of the current window |
| res_count | output | 32 | Tuples accepted in the current window |
| res_sum | output | 32 | Wrapping sum of accepted values |
| res_min | output | 32 | Smallest accepted value |
| res_max | output | 32 | Largest accepted value |

## Verification
The in-RTL assertions check these properties on every cycle:
- accept and close never coincide;
- close never occurs without punctuation;
- the bounds step by exactly the bank stride on a close and stay still otherwise;
- the count increments on an accept;
- the aggregates are frozen when nothing happens and cleared after a close;
- an empty window holds reset values.

Only the bench's scenarios can show the rest:
- the exact reset bounds for a given slot index;
- the correct SUM, MIN and MAX values over out-of-order arrivals;
- the wrap of SUM;
- the visibility of the final results in the close cycle.

// File: rtl/wagg_pkg.sv
package wagg_pkg;

    localparam int unsigned DW = 32;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [0:0] {
        WS_EMPTY = 1'b0,
        WS_OPEN  = 1'b1
    } win_state_e;

    typedef struct packed {
        word_t cnt;
        word_t sum;
        word_t mn;
        word_t mx;
    } agg_t;

    localparam agg_t AGG_RESET = '{cnt: '0, sum: '0, mn: '1, mx: '0};

    function automatic word_t umin(input word_t a, input word_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic word_t umax(input word_t a, input word_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wagg_bounds.sv
module wagg_bounds
    import wagg_pkg::*;
#(
    parameter int unsigned INST_IDX  = 1,
    parameter int unsigned RANGE_LEN = 600,
    parameter int unsigned SLIDE_LEN = 60,
    parameter int unsigned NUM_INST  = 11,
    parameter int unsigned START_TS  = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_punct,
    input  word_t in_ts,
    output logic  accept_o,
    output logic  close_o,
    output word_t end_o
);

    localparam word_t BEGIN0 = word_t'(START_TS + (INST_IDX - 1) * SLIDE_LEN);
    localparam word_t END0   = word_t'(BEGIN0 + RANGE_LEN);
    localparam word_t STEP   = word_t'(NUM_INST * SLIDE_LEN);

    word_t begin_q;
    word_t end_q;
    logic  in_win;
    logic  past_end;

    always_comb begin
        in_win   = (in_ts >= begin_q) && (in_ts < end_q);
        past_end = (in_ts >= end_q);
        accept_o = 1'b0;
        close_o  = 1'b0;
        if (in_punct) begin
            close_o = past_end;
        end else begin
            accept_o = in_valid && in_win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            begin_q <= BEGIN0;
            end_q   <= END0;
        end else if (close_o) begin
            begin_q <= begin_q + STEP;
            end_q   <= end_q + STEP;
        end
    end

    assign end_o = end_q;

    // R6
    acc_not_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !close_o);

    // R7
    no_close_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_punct |-> !close_o);

    // R2
    bound_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> (begin_q == $past(begin_q) + STEP) && (end_q == $past(end_q) + STEP));

    // R3
    bound_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !close_o |=> $stable(begin_q) && $stable(end_q));

endmodule

// File: rtl/wagg_accum.sv
module wagg_accum
    import wagg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  accept_i,
    input  logic  close_i,
    input  word_t val_i,
    output agg_t  agg_o
);

    win_state_e state_q, state_d;
    agg_t       agg_q, agg_d;
    agg_t       folded;

    always_comb begin
        folded.cnt = agg_q.cnt + word_t'(1);
        folded.sum = agg_q.sum + val_i;
        folded.mn  = umin(agg_q.mn, val_i);
        folded.mx  = umax(agg_q.mx, val_i);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_EMPTY: if (accept_i) state_d = WS_OPEN;
            WS_OPEN:  if (close_i)  state_d = WS_EMPTY;
        endcase
    end

    always_comb begin
        agg_d = agg_q;
        unique case (state_q)
            WS_EMPTY: begin
                if (accept_i) agg_d = folded;
                else          agg_d = AGG_RESET;
            end
            WS_OPEN: begin
                if (close_i)       agg_d = AGG_RESET;
                else if (accept_i) agg_d = folded;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) agg_q <= AGG_RESET;
        else        agg_q <= agg_d;
    end

    assign agg_o = agg_q;

    // R11
    empty_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_EMPTY) |-> (agg_q.cnt == '0 && agg_q.sum == '0 && agg_q.mn == '1 && agg_q.mx == '0));

    // R4
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> agg_q.cnt == $past(agg_q.cnt) + word_t'(1));

    // R5
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !close_i) |=> $stable(agg_q));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |=> (agg_q.cnt == '0 && agg_q.mn == '1 && state_q == WS_EMPTY));

    // R4
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_OPEN) |-> (agg_q.mn <= agg_q.mx));

endmodule

// File: rtl/wagg_unit.sv
module wagg_unit
    import wagg_pkg::*;
#(
    parameter int unsigned INST_IDX  = 1,
    parameter int unsigned RANGE_LEN = 600,
    parameter int unsigned SLIDE_LEN = 60,
    parameter int unsigned NUM_INST  = 11,
    parameter int unsigned START_TS  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_punct,
    input  logic [DW-1:0] in_ts,
    input  logic [DW-1:0] in_val,
    output logic          win_close,
    output logic [DW-1:0] win_end_ts,
    output logic [DW-1:0] res_count,
    output logic [DW-1:0] res_sum,
    output logic [DW-1:0] res_min,
    output logic [DW-1:0] res_max
);

    logic  accept;
    logic  close;
    word_t end_ts;
    agg_t  agg;

    wagg_bounds #(
        .INST_IDX (INST_IDX),
        .RANGE_LEN(RANGE_LEN),
        .SLIDE_LEN(SLIDE_LEN),
        .NUM_INST (NUM_INST),
        .START_TS (START_TS)
    ) u_bounds (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_punct(in_punct),
        .in_ts   (in_ts),
        .accept_o(accept),
        .close_o (close),
        .end_o   (end_ts)
    );

    wagg_accum u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .close_i (close),
        .val_i   (in_val),
        .agg_o   (agg)
    );

    assign win_close  = close;
    assign win_end_ts = end_ts;
    assign res_count  = agg.cnt;
    assign res_sum    = agg.sum;
    assign res_min    = agg.mn;
    assign res_max    = agg.mx;

endmodule

// File: tb/test_wagg_unit.sv
module test_wagg_unit;

    localparam int unsigned P_IDX   = 3;
    localparam int unsigned P_RANGE = 600;
    localparam int unsigned P_SLIDE = 60;
    localparam int unsigned P_NUM   = 11;
    localparam int unsigned P_START = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_punct = 1'b0;
    logic [31:0] in_ts = '0;
    logic [31:0] in_val = '0;
    logic        win_close;
    logic [31:0] win_end_ts, res_count, res_sum, res_min, res_max;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_begin, m_end, m_cnt, m_sum, m_min, m_max;

    always #5 clk = ~clk;

    wagg_unit #(
        .INST_IDX(P_IDX), .RANGE_LEN(P_RANGE), .SLIDE_LEN(P_SLIDE),
        .NUM_INST(P_NUM), .START_TS(P_START)
    ) i_wagg_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_punct(in_punct),
        .in_ts(in_ts), .in_val(in_val), .win_close(win_close),
        .win_end_ts(win_end_ts), .res_count(res_count), .res_sum(res_sum),
        .res_min(res_min), .res_max(res_max)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_close(input logic p, input logic [31:0] ts);
        return p && (ts >= m_end);
    endfunction

    function automatic logic exp_accept(input logic v, input logic p, input logic [31:0] ts);
        return v && !p && (ts >= m_begin) && (ts < m_end);
    endfunction

    task automatic model_reset();
        m_begin = P_START + (P_IDX - 1) * P_SLIDE;
        m_end   = m_begin + P_RANGE;
        m_cnt = '0; m_sum = '0; m_min = '1; m_max = '0;
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " end"}, win_end_ts, m_end);
        chk({tag, " count"}, res_count, m_cnt);
        chk({tag, " sum"}, res_sum, m_sum);
        chk({tag, " min"}, res_min, m_min);
        chk({tag, " max"}, res_max, m_max);
    endtask

    task automatic beat(input logic v, input logic p, input logic [31:0] ts,
                        input logic [31:0] val, input string tag);
        logic c, a;
        @(negedge clk);
        check_regs(tag);
        in_valid = v; in_punct = p; in_ts = ts; in_val = val;
        c = exp_close(p, ts);
        a = exp_accept(v, p, ts);
        #1;
        chk({tag, " close R2/R3/R7"}, {31'd0, win_close}, {31'd0, c});
        @(posedge clk);
        if (c) begin
            m_begin = m_begin + P_NUM * P_SLIDE;
            m_end   = m_end + P_NUM * P_SLIDE;
            m_cnt = '0; m_sum = '0; m_min = '1; m_max = '0;
        end else if (a) begin
            m_cnt = m_cnt + 1;
            m_sum = m_sum + val;
            if (val < m_min) m_min = val;
            if (val > m_max) m_max = val;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state with literal values
        chk("R1 reset end", win_end_ts, 32'd1720);
        chk("R1 reset count", res_count, 32'd0);
        chk("R1 reset sum", res_sum, 32'd0);
        chk("R1 reset min", res_min, 32'hFFFF_FFFF);
        chk("R1 reset max", res_max, 32'd0);

        // R4 R9 out-of-order tuples inside the window
        beat(1, 0, 32'd1500, 32'd10, "R4 t1");
        beat(1, 0, 32'd1130, 32'd7,  "R9 t2");
        beat(1, 0, 32'd1700, 32'd30, "R9 t3");
        beat(1, 0, 32'd1120, 32'd12, "R4 begin edge");
        // R5 outside and invalid beats
        beat(1, 0, 32'd1119, 32'd99, "R5 below");
        beat(1, 0, 32'd1720, 32'd99, "R5 at end");
        beat(0, 0, 32'd1500, 32'd99, "R5 novalid");
        // R6 valid with punctuation, inside window
        beat(1, 1, 32'd1600, 32'd5,  "R6 both");
        // R3 punctuation below end
        beat(0, 1, 32'd1719, 32'd0,  "R3 early punct");
        // R10 wrap of sum
        beat(1, 0, 32'd1200, 32'hFFFF_FFF0, "R10 big");
        beat(1, 0, 32'd1201, 32'h20, "R10 wrap");
        @(negedge clk);
        chk("R4 count literal", res_count, 32'd6);
        chk("R10 sum literal", res_sum, 32'd10 + 32'd7 + 32'd30 + 32'd12 + 32'h10);
        chk("R4 min literal", res_min, 32'd7);
        chk("R4 max literal", res_max, 32'hFFFF_FFF0);
        // R8 close cycle shows final values and old end
        in_valid = 0; in_punct = 1; in_ts = 32'd1720; in_val = 0;
        #1;
        chk("R8 close strobe", {31'd0, win_close}, 32'd1);
        chk("R8 end during close", win_end_ts, 32'd1720);
        chk("R8 count during close", res_count, 32'd6);
        @(posedge clk);
        m_begin = m_begin + 660; m_end = m_end + 660;
        m_cnt = '0; m_sum = '0; m_min = '1; m_max = '0;
        @(negedge clk);
        chk("R2 end advanced", win_end_ts, 32'd2380);
        chk("R8 count cleared", res_count, 32'd0);
        chk("R8 min cleared", res_min, 32'hFFFF_FFFF);
        // R3 old punctuation no longer closes
        beat(0, 1, 32'd1720, 32'd0, "R3 stale punct");
        // R11 empty window close still advances
        beat(0, 1, 32'd5000, 32'd0, "R11 empty close");
        @(negedge clk);
        chk("R11 end after empty close", win_end_ts, 32'd3040);
        in_punct = 0;
        // R7 no close without punctuation
        beat(1, 0, 32'hFFFF_FFFF, 32'd1, "R7 huge ts");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic p, v;
            logic [31:0] ts, val;
            p = ($urandom_range(0, 7) == 0);
            v = ($urandom_range(0, 3) != 0);
            if (p) ts = m_end - 32'd30 + $urandom_range(0, 80);
            else   ts = m_begin - 32'd200 + $urandom_range(0, P_RANGE + 400);
            val = ($urandom_range(0, 9) == 0) ? $urandom() : $urandom_range(0, 1000);
            beat(v, p, ts, val, "R4/R5/R9 random");
        end
        @(negedge clk);
        check_regs("R4 final");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule